// File: doc/BRIEF.md
# Configurable SPI Master/Slave Shifter

This block is a serial peripheral engine that can act either as the clock-driving master or as a selected slave on an SPI bus. Software programs the clock polarity, the clock phase, the shift order (most or least significant bit first), the frame width (8 or 16 bits) and a divider for the master clock. It then writes a data word to send and reads back the word that arrived. The shift order only changes the order of bits on the wire. The data word always keeps its most significant bit at the top of the active width, bit 7 for 8-bit frames and bit 15 for 16-bit frames.

Three control bits decide what the slave-select pin does: the master bit, a fault-detect enable and a select-output enable. In master mode the pin can be left alone as general-purpose I/O, read as a mode-fault input, or driven as an automatic select that frames each transfer. In slave mode the pin is always the select input. When a master sees its fault input pulled low, it drops to slave role and releases the bus. After each received frame the block compares the data with a programmable compare word and raises a sticky flag when they are equal.

Top module: `spi_shifter`

## Requirements
- R1: In master mode, whenever no transfer is in progress, the clock pin rests at the programmed polarity level: 0 when polarity is 0 and 1 when polarity is 1.
- R2: With phase 0 the first bit appears on the data line before the first clock edge, and each bit is sampled on every leading edge. With phase 1 each bit is driven on a leading edge and sampled on every trailing edge. Full-duplex data is exchanged correctly in all four polarity/phase combinations.
- R3: With least-significant-first selected, bit 0 goes out first. With most-significant-first selected, bit 7 (or bit 15 in 16-bit mode) goes out first. Words written and read keep the same bit layout in both orders.
- R4: With the wide bit set, a frame is 16 bits long. With the wide bit clear, it is 8 bits long, uses bits 7..0 and reads back with bits 15..8 at zero.
- R5: The select output enable is high only when the block is master with fault detect on and select output on. In master mode with fault detect off, a low select pin has no effect. With select output on, a low select pin causes no fault either.
- R6: The automatic select goes low exactly one half clock period (divider+1 system cycles) before the first clock edge. It goes high one half period after the last edge.
- R7: As master with fault detect on and select output off, a low select pin sets the fault flag, clears the master bit and drops the clock and data output enables. The flag stays set until cleared by a 1 written to its clear input.
- R8: The match flag sets when a completed frame equals the compare word. It stays set until it is cleared by a 1 written to its clear input. A frame that does not equal the compare word leaves it clear.
- R9: In 8-bit mode the high compare byte reads as zero, writes to it are dropped, and only the low byte takes part in the compare.
- R10: As slave, the block shifts only while its select input is low. It drives its output data line (with output enable) only while selected, and it exchanges frames correctly for both phases.
- R11: In master mode, consecutive clock edges within a frame are exactly divider+1 system cycles apart.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ctl_wr | input | 1 | Load all control fields below |
| ctl_master | input | 1 | Master role when 1 |
| ctl_cpol | input | 1 | Clock polarity (idle level) |
| ctl_cpha | input | 1 | Clock phase |
| ctl_lsb_first | input | 1 | Shift least significant bit first |
| ctl_wide | input | 1 | 16-bit frames when 1, else 8-bit |
| ctl_fault_en | input | 1 | Enable select pin for fault input / auto select |
| ctl_ss_auto | input | 1 | Select output enable |
| ctl_div | input | DIV_W | Half clock period minus one, in system cycles |
| tx_wr | input | 1 | Write transmit word; starts a master transfer when idle |
| tx_data | input | 16 | Transmit word |
| rx_data | output | 16 | Last received word |
| cmp_lo_wr | input | 1 | Write low compare byte |
| cmp_hi_wr | input | 1 | Write high compare byte (dropped in 8-bit mode) |
| cmp_wdata | input | 8 | Compare byte value |
| cmp_lo_q | output | 8 | Low compare byte |
| cmp_hi_q | output | 8 | High compare byte, zero in 8-bit mode |
| match_flag | output | 1 | Sticky match flag |
| match_clr | input | 1 | Write-1 clear of match flag |
| fault_flag | output | 1 | Sticky mode-fault flag |
| fault_clr | input | 1 | Write-1 clear of fault flag |
| master_o | output | 1 | Current master bit |
| busy | output | 1 | Master transfer in progress |
| sck_i | input | 1 | Clock pin input |
| sck_o | output | 1 | Clock pin output |
| sck_oe | output | 1 | Clock pin output enable |
| mosi_i | input | 1 | Master-out line input |
| mosi_o | output | 1 | Master-out line output |
| mosi_oe | output | 1 | Master-out output enable |
| miso_i | input | 1 | Master-in line input |
| miso_o | output | 1 | Master-in line output |
| miso_oe | output | 1 | Master-in output enable |
| ss_i | input | 1 | Select pin input |
| ss_o | output | 1 | Select pin output |
| ss_oe | output | 1 | Select pin output enable |

## Verification
On every cycle, the embedded assertions check four things: the clock resting level while the master is idle, that a clock edge only follows a divider terminal count, that the master bit is gone once a fault is flagged, and that neither the match flag nor the locked high compare byte changes on its own. Only the bench scenarios can show the rest. These are the bit-exact data exchanged in each phase, polarity and order, the half-period spacing between the select edges and the clock edges, and the chain from fault to role change. They also cover whether a given frame matches the compare word in each width.

// File: rtl/spi_shifter.sv
module spi_shifter #(
  parameter int DIV_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ctl_wr,
  input  logic             ctl_master,
  input  logic             ctl_cpol,
  input  logic             ctl_cpha,
  input  logic             ctl_lsb_first,
  input  logic             ctl_wide,
  input  logic             ctl_fault_en,
  input  logic             ctl_ss_auto,
  input  logic [DIV_W-1:0] ctl_div,
  input  logic             tx_wr,
  input  logic [15:0]      tx_data,
  output logic [15:0]      rx_data,
  input  logic             cmp_lo_wr,
  input  logic             cmp_hi_wr,
  input  logic [7:0]       cmp_wdata,
  output logic [7:0]       cmp_lo_q,
  output logic [7:0]       cmp_hi_q,
  output logic             match_flag,
  input  logic             match_clr,
  output logic             fault_flag,
  input  logic             fault_clr,
  output logic             master_o,
  output logic             busy,
  input  logic             sck_i,
  output logic             sck_o,
  output logic             sck_oe,
  input  logic             mosi_i,
  output logic             mosi_o,
  output logic             mosi_oe,
  input  logic             miso_i,
  output logic             miso_o,
  output logic             miso_oe,
  input  logic             ss_i,
  output logic             ss_o,
  output logic             ss_oe
);
  localparam int CNT_W = 5;

  typedef enum logic [1:0] {IDLE, LEAD, RUN, TRAIL} st_t;
  st_t st;

  logic master_q, cpol_q, cpha_q, lsb_q, wide_q, fen_q, ssa_q;
  logic [DIV_W-1:0] div_q, divcnt;
  logic [CNT_W-1:0] ecnt, tcnt, rcnt;
  logic lvl;
  logic [15:0] txq, rxq, rx_nx;
  logic [7:0] cmp_lo, cmp_hi;
  logic [1:0] sck_s, mosi_s, ss_s;
  logic sck_prev, ss_prev;

  logic [3:0] nbm1, tidx, ridx;
  logic tick, m_edge, s_act, s_edge, ev, ev_lvl, do_sample, do_shift;
  logic frame_end, s_start, fault_now, in_bit;
  logic [15:0] cmp_val;

  assign nbm1      = wide_q ? 4'd15 : 4'd7;
  assign tidx      = lsb_q ? tcnt[3:0] : nbm1 - tcnt[3:0];
  assign ridx      = lsb_q ? rcnt[3:0] : nbm1 - rcnt[3:0];
  assign tick      = (divcnt == div_q);
  assign m_edge    = master_q && (st == LEAD || st == RUN) && tick;
  assign s_act     = !master_q && !ss_s[1];
  assign s_edge    = s_act && (sck_s[1] != sck_prev);
  assign ev        = m_edge || s_edge;
  assign ev_lvl    = master_q ? ~lvl : (sck_s[1] ^ cpol_q);
  assign do_sample = ev && (ev_lvl != cpha_q);
  assign do_shift  = ev && !do_sample;
  assign frame_end = do_sample && (rcnt[3:0] == nbm1);
  assign s_start   = !master_q && !ss_s[1] && ss_prev;
  assign fault_now = master_q && fen_q && !ssa_q && !ss_s[1];
  assign in_bit    = master_q ? miso_i : mosi_s[1];
  assign cmp_val   = wide_q ? {cmp_hi, cmp_lo} : {8'h00, cmp_lo};

  always_comb begin
    rx_nx       = rxq;
    rx_nx[ridx] = in_bit;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= IDLE;
      master_q <= 1'b0; cpol_q <= 1'b0; cpha_q <= 1'b0; lsb_q <= 1'b0;
      wide_q <= 1'b0; fen_q <= 1'b0; ssa_q <= 1'b0; div_q <= '0;
      divcnt <= '0; ecnt <= '0; tcnt <= '0; rcnt <= '0; lvl <= 1'b0;
      txq <= '0; rxq <= '0; rx_data <= '0;
      cmp_lo <= '0; cmp_hi <= '0;
      match_flag <= 1'b0; fault_flag <= 1'b0;
      sck_s <= '0; mosi_s <= '0; ss_s <= 2'b11;
      sck_prev <= 1'b0; ss_prev <= 1'b1;
    end else begin
      sck_s    <= {sck_s[0], sck_i};
      mosi_s   <= {mosi_s[0], mosi_i};
      ss_s     <= {ss_s[0], ss_i};
      sck_prev <= sck_s[1];
      ss_prev  <= ss_s[1];

      if (ctl_wr) begin
        master_q <= ctl_master; cpol_q <= ctl_cpol; cpha_q <= ctl_cpha;
        lsb_q <= ctl_lsb_first; wide_q <= ctl_wide; fen_q <= ctl_fault_en;
        ssa_q <= ctl_ss_auto; div_q <= ctl_div;
      end
      if (cmp_lo_wr) cmp_lo <= cmp_wdata;
      if (cmp_hi_wr && wide_q) cmp_hi <= cmp_wdata;
      if (match_clr) match_flag <= 1'b0;
      if (fault_clr) fault_flag <= 1'b0;

      if (tx_wr && (!master_q || st == IDLE)) txq <= tx_data;
      if (tx_wr && master_q && st == IDLE && !ctl_wr) begin
        st <= LEAD; divcnt <= '0; ecnt <= '0; lvl <= 1'b0;
        tcnt <= '0; rcnt <= '0; rxq <= '0;
      end

      if (st != IDLE) begin
        if (tick) begin
          divcnt <= '0;
          if (st == TRAIL) st <= IDLE;
          else begin
            ecnt <= ecnt + 1'b1;
            lvl  <= ~lvl;
            st   <= (ecnt == {nbm1, 1'b1}) ? TRAIL : RUN;
          end
        end else begin
          divcnt <= divcnt + 1'b1;
        end
      end

      if (s_start) begin
        tcnt <= '0; rcnt <= '0; rxq <= '0;
      end
      if (do_shift) tcnt <= rcnt;
      if (do_sample) begin
        if (frame_end) begin
          rcnt <= '0; rxq <= '0; rx_data <= rx_nx;
          if (rx_nx == cmp_val) match_flag <= 1'b1;
        end else begin
          rcnt <= rcnt + 1'b1; rxq <= rx_nx;
        end
      end

      if (fault_now) begin
        fault_flag <= 1'b1; master_q <= 1'b0; st <= IDLE; lvl <= 1'b0;
      end
    end
  end

  assign cmp_lo_q = cmp_lo;
  assign cmp_hi_q = wide_q ? cmp_hi : 8'h00;
  assign master_o = master_q;
  assign busy     = (st != IDLE);
  assign sck_o    = cpol_q ^ lvl;
  assign sck_oe   = master_q;
  assign mosi_o   = txq[tidx];
  assign mosi_oe  = master_q;
  assign miso_o   = txq[tidx];
  assign miso_oe  = !master_q && !ss_s[1];
  assign ss_o     = (st == IDLE);
  assign ss_oe    = master_q && fen_q && ssa_q;

  assert_sck_idle_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (master_q && st == IDLE) |-> (sck_o == cpol_q));

  assert_edge_on_tick_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (master_q && sck_o != $past(sck_o) && !$past(ctl_wr)) |-> ($past(divcnt) == $past(div_q)));

  assert_fault_drops_role_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(fault_flag) |-> !master_q);

  assert_match_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (match_flag && !match_clr) |=> match_flag);

  assert_hi_locked_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (!wide_q && cmp_hi_wr) |=> $stable(cmp_hi));
endmodule

// File: tb/spi_shifter_tb_top.sv
module spi_shifter_tb_top;
  logic clk = 1'b0, rst_n = 1'b0;
  always #5 clk = ~clk;

  logic ctl_wr = 0, ctl_master = 0, ctl_cpol = 0, ctl_cpha = 0, ctl_lsb_first = 0;
  logic ctl_wide = 0, ctl_fault_en = 0, ctl_ss_auto = 0;
  logic [7:0] ctl_div = 0;
  logic tx_wr = 0; logic [15:0] tx_data = 0; logic [15:0] rx_data;
  logic cmp_lo_wr = 0, cmp_hi_wr = 0; logic [7:0] cmp_wdata = 0;
  logic [7:0] cmp_lo_q, cmp_hi_q;
  logic match_flag, match_clr = 0, fault_flag, fault_clr = 0, master_o, busy;
  logic sck_i = 0, sck_o, sck_oe, mosi_i = 0, mosi_o, mosi_oe;
  logic miso_i, miso_o, miso_oe, ss_i = 1, ss_o, ss_oe;
  logic miso_drv = 0;
  assign miso_i = miso_drv;

  spi_shifter #(.DIV_W(8)) dut_i (
    .clk, .rst_n, .ctl_wr, .ctl_master, .ctl_cpol, .ctl_cpha, .ctl_lsb_first,
    .ctl_wide, .ctl_fault_en, .ctl_ss_auto, .ctl_div, .tx_wr, .tx_data, .rx_data,
    .cmp_lo_wr, .cmp_hi_wr, .cmp_wdata, .cmp_lo_q, .cmp_hi_q, .match_flag, .match_clr,
    .fault_flag, .fault_clr, .master_o, .busy, .sck_i, .sck_o, .sck_oe, .mosi_i,
    .mosi_o, .mosi_oe, .miso_i, .miso_o, .miso_oe, .ss_i, .ss_o, .ss_oe);

  int checks = 0, errors = 0;
  bit e_master = 0, e_cpol = 0, e_cpha = 0, e_lsb = 0, e_wide = 0, e_fen = 0, e_ssa = 0;
  int e_div = 0;
  bit mon_en = 0;
  logic [15:0] slv_tx = 0, sacc = 0;
  int sb = 0, since = 0;
  logic p_ss = 1, p_sck = 0;

  task automatic chk(input string req, input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic int nbits();
    return e_wide ? 16 : 8;
  endfunction
  function automatic int bpos(input int k);
    return e_lsb ? k : nbits() - 1 - k;
  endfunction
  function automatic logic [15:0] mask();
    return e_wide ? 16'hFFFF : 16'h00FF;
  endfunction

  // reference model: pin roles every clock, and a behavioural slave for master runs
  always @(negedge clk) begin
    if (rst_n && mon_en) begin
      chk("R5 sck_oe role", sck_oe, e_master);
      chk("R5 mosi_oe role", mosi_oe, e_master);
      chk("R5 ss_oe role", ss_oe, e_master && e_fen && e_ssa);
      chk("R7 master bit", master_o, e_master);
      if (e_master && ss_o) chk("R1 idle clock level", sck_o, e_cpol);
      if (e_master) begin
        since++;
        if (ss_o != p_ss) begin
          if (ss_o) chk("R6 select rise delay", since, e_div + 1);
          else begin
            sb = 0; sacc = 0; miso_drv = slv_tx[bpos(0)];
          end
          since = 0;
        end else if (sck_o != p_sck && !ss_o) begin
          chk("R11 half period", since, e_div + 1);
          since = 0;
          if ((sck_o ^ e_cpol) != e_cpha) begin
            sacc[bpos(sb)] = mosi_o; sb++;
          end else if (sb < nbits()) miso_drv = slv_tx[bpos(sb)];
        end
      end
    end
    p_ss = ss_o; p_sck = sck_o;
  end

  task automatic cfg(input bit m, cp, ph, lsb, wide, fen, ssa, input int dv);
    mon_en = 0;
    @(negedge clk);
    ctl_master = m; ctl_cpol = cp; ctl_cpha = ph; ctl_lsb_first = lsb; ctl_wide = wide;
    ctl_fault_en = fen; ctl_ss_auto = ssa; ctl_div = dv[7:0]; ctl_wr = 1; sck_i = cp;
    @(negedge clk); ctl_wr = 0;
    e_master = m; e_cpol = cp; e_cpha = ph; e_lsb = lsb; e_wide = wide;
    e_fen = fen; e_ssa = ssa; e_div = dv;
    @(negedge clk); mon_en = 1;
  endtask

  task automatic m_xfer(input logic [15:0] mtx, input logic [15:0] stx, input string req);
    slv_tx = stx;
    @(negedge clk); tx_data = mtx; tx_wr = 1;
    @(negedge clk); tx_wr = 0;
    chk({req, " busy at start"}, busy, 1);
    while (busy) @(negedge clk);
    repeat (2) @(negedge clk);
    chk({req, " master received"}, rx_data, stx & mask());
    chk({req, " slave received"}, sacc, mtx & mask());
  endtask

  task automatic s_xfer(input logic [15:0] mtx, input logic [15:0] dtx, input string req);
    logic [15:0] got;
    int b;
    got = 0; b = 0;
    @(negedge clk); tx_data = dtx; tx_wr = 1;
    @(negedge clk); tx_wr = 0; ss_i = 0; mosi_i = mtx[bpos(0)];
    repeat (6) @(negedge clk);
    chk("R10 miso driven while selected", miso_oe, 1);
    for (int e = 0; e < 2 * nbits(); e++) begin
      if (((e % 2) == 0) != e_cpha) begin
        got[bpos(b)] = miso_o; b++;
      end else if (b < nbits()) mosi_i = mtx[bpos(b)];
      sck_i = ~sck_i;
      repeat (6) @(negedge clk);
    end
    ss_i = 1;
    repeat (6) @(negedge clk);
    chk("R10 miso released", miso_oe, 0);
    chk({req, " slave received"}, rx_data, mtx & mask());
    chk({req, " bench master received"}, got, dtx & mask());
  endtask

  task automatic pulse_cmp(input bit hi, input logic [7:0] v);
    @(negedge clk); cmp_wdata = v; cmp_lo_wr = !hi; cmp_hi_wr = hi;
    @(negedge clk); cmp_lo_wr = 0; cmp_hi_wr = 0;
    @(negedge clk);
  endtask

  task automatic clr_match();
    @(negedge clk); match_clr = 1;
    @(negedge clk); match_clr = 0;
    @(negedge clk);
  endtask

  task automatic summary();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired actual=hung expected=done");
    summary();
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk("R7 reset master bit", master_o, 0);
    chk("R5 reset ss_oe", ss_oe, 0);
    chk("R8 reset match flag", match_flag, 0);
    chk("R7 reset fault flag", fault_flag, 0);
    chk("R4 reset rx word", rx_data, 0);

    cfg(1, 0, 0, 0, 0, 1, 1, 2);
    m_xfer(16'h00A5, 16'h003C, "R2 mode0 msb");
    cfg(1, 0, 1, 0, 0, 1, 1, 1);
    m_xfer(16'h0096, 16'h0071, "R2 mode1 msb");
    cfg(1, 1, 0, 1, 0, 1, 1, 3);
    m_xfer(16'h000D, 16'h00B2, "R3 mode2 lsb");
    cfg(1, 1, 1, 1, 1, 1, 1, 0);
    m_xfer(16'h1234, 16'hC0DE, "R4 mode3 wide lsb");
    cfg(1, 0, 0, 0, 1, 0, 0, 1);
    m_xfer(16'hBEEF, 16'h0F1E, "R4 wide msb");

    @(negedge clk); ss_i = 0;
    repeat (6) @(negedge clk);
    chk("R5 no fault with detect off", fault_flag, 0);
    cfg(1, 0, 0, 0, 0, 1, 1, 1);
    repeat (6) @(negedge clk);
    chk("R5 no fault with select output on", fault_flag, 0);
    @(negedge clk); ss_i = 1;

    cfg(1, 0, 0, 0, 0, 1, 0, 1);
    mon_en = 0;
    @(negedge clk); ss_i = 0;
    repeat (5) @(negedge clk);
    chk("R7 fault flag set", fault_flag, 1);
    chk("R7 master cleared", master_o, 0);
    chk("R7 sck released", sck_oe, 0);
    chk("R7 mosi released", mosi_oe, 0);
    e_master = 0;
    ss_i = 1;
    repeat (4) @(negedge clk);
    chk("R7 fault flag sticky", fault_flag, 1);
    fault_clr = 1; @(negedge clk); fault_clr = 0; @(negedge clk);
    chk("R7 fault flag cleared", fault_flag, 0);
    mon_en = 1;

    cfg(0, 0, 0, 0, 0, 0, 0, 0);
    chk("R10 idle miso released", miso_oe, 0);
    s_xfer(16'h005C, 16'h00E3, "R10 slave phase0");
    cfg(0, 1, 1, 1, 1, 0, 0, 0);
    s_xfer(16'h8421, 16'h7BDE, "R10 slave phase1 wide");

    pulse_cmp(0, 8'h21);
    pulse_cmp(1, 8'h84);
    chk("R8 flag before match", match_flag, 0);
    s_xfer(16'h8421, 16'h0001, "R8 matching frame");
    chk("R8 flag set on match", match_flag, 1);
    repeat (5) @(negedge clk);
    chk("R8 flag sticky", match_flag, 1);
    clr_match();
    chk("R8 flag cleared", match_flag, 0);
    s_xfer(16'h8422, 16'h0002, "R8 non-matching frame");
    chk("R8 no flag on mismatch", match_flag, 0);

    cfg(0, 0, 0, 0, 0, 0, 0, 0);
    chk("R9 high byte reads zero", cmp_hi_q, 0);
    pulse_cmp(1, 8'hFF);
    chk("R9 high byte still zero", cmp_hi_q, 0);
    pulse_cmp(0, 8'h5C);
    s_xfer(16'h005C, 16'h0011, "R9 8-bit frame");
    chk("R9 low byte alone matches", match_flag, 1);
    clr_match();
    cfg(0, 0, 0, 0, 1, 0, 0, 0);
    chk("R9 high byte write dropped", cmp_hi_q, 8'h84);

    repeat (4) @(negedge clk);
    summary();
    $finish;
  end
endmodule